// File: doc/BRIEF.md
# Branch Expected-Direction Checker

This block guards the control flow of one running function. It holds a small expected-direction record for every tracked branch. Each record says that the next run of the branch must be taken, must be not-taken, or may go either way. A stream of ordered requests drives it. A verify request compares the real outcome of a committed branch with its record and raises an alarm on a conflict. An update request walks a list of correlation actions, prepared ahead of time by software in an external action table, and rewrites the records of the branches that the executed branch constrains.

Requests arrive on a valid/ready interface. A request transfers on a rising clock edge where both `req_valid` and `req_ready` are high. The source must hold the request fields steady while `req_valid` is high and `req_ready` is low. The block drops `req_ready` for as long as it walks an action list and while `func_start` is high. It therefore handles exactly one request at a time, in arrival order. The action table is read through a port with one cycle of latency. Each table entry holds one action and a pointer to the next entry, so an update costs one cycle per entry.

Top module: `brc_dir_checker`

## Requirements
- R1: After reset, and after any cycle with `func_start` high, every branch record is unknown (held internally as code 11, with 01 = taken and 10 = not-taken), so a verify of either direction raises no alarm.
- R2: A verify request (`req_kind` = 0) whose record is taken or not-taken and disagrees with `req_taken` sets `alarm` in the cycle after the transfer, and `alarm_idx` gives the failing branch.
- R3: A verify request against an unknown record never raises the alarm, whatever `req_taken` is.
- R4: An update request (`req_kind` = 1) for branch b with outcome t starts its list at table address 2*b+t. An entry has the action in bits [1:0] (00 keep, 01 set taken, 10 set not-taken, 11 set unknown), the target branch in bits [IDX_W+1:2], the last-entry flag in bit IDX_W+2, and the next address in the bits above that.
- R5: The taken and not-taken outcomes of the same branch use separate lists, so they can leave different records behind.
- R6: An entry may target the branch being updated, which sets that branch's own record.
- R7: An update whose list has L entries reads one entry per cycle and holds `req_ready` low for exactly L cycles after the transfer.
- R8: Requests take effect in transfer order. A verify that transfers right after an update sees every record change that the update made.
- R9: `alarm` stays set, and `alarm_idx` keeps the first failing branch, until `alarm_clr` is pulsed. A failure in the same cycle as `alarm_clr` leaves the alarm set and reports the new branch.
- R10: An entry with the keep action leaves its target's record unchanged.
- R11: A verify request changes no record. Verifying the same conflicting outcome again, after a clear, raises the alarm again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_start | input | 1 | Resets all records to unknown for a new function |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_kind | input | 1 | 0 = verify, 1 = update |
| req_idx | input | IDX_W | Branch index |
| req_taken | input | 1 | Actual outcome of the branch |
| tbl_rd_en | output | 1 | Action table read strobe |
| tbl_addr | output | ADDR_W | Action table read address |
| tbl_rd_data | input | ENT_W | Entry read, valid the cycle after the strobe |
| alarm_clr | input | 1 | Clears the sticky alarm |
| alarm | output | 1 | Anomaly alarm, sticky |
| alarm_idx | output | IDX_W | Branch that first failed its check |

## Verification
The main function is driven with three kinds of pattern. Verifies against fresh unknown records show that unknown accepts both outcomes. Verifies after a single-entry list on each outcome of one branch show that the two lists are kept apart. Verifies after chained lists that mix keep, self-target and set actions show that each action reaches its own target and no other. Back-to-back update-then-verify pairs, the count of not-ready cycles per list length, and an alarm clear that coincides with a new failure separate ordering and alarm timing faults from faults in the actions themselves.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_SET_T  = 2'b01,
    ACT_SET_NT = 2'b10,
    ACT_SET_UN = 2'b11
  } act_e;

  localparam logic [1:0] ST_T  = 2'b01;
  localparam logic [1:0] ST_NT = 2'b10;
  localparam logic [1:0] ST_UN = 2'b11;

  localparam logic REQ_VERIFY = 1'b0;
  localparam logic REQ_UPDATE = 1'b1;
endpackage

// File: rtl/brc_state_bank.sv
module brc_state_bank
  import brc_pkg::*;
#(
  parameter int NUM_BR = 16,
  parameter int IDX_W  = $clog2(NUM_BR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_code,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_code
);
  logic [NUM_BR-1:0][1:0] st;

  for (genvar g = 0; g < NUM_BR; g++) begin : g_rec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    st[g] <= ST_UN;
      else if (clear_all)                            st[g] <= ST_UN;
      else if (wr_en && wr_idx == IDX_W'(g))         st[g] <= wr_code;
    end

    // R1
    rec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] != 2'b00);

    // R1
    rec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> st[g] == ST_UN);
  end

  always_comb begin
    rd_code = ST_UN;
    if (int'(rd_idx) < NUM_BR) rd_code = st[rd_idx];
  end
endmodule

// File: rtl/brc_action_walker.sv
module brc_action_walker
  import brc_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 6,
  localparam int ENT_W = ADDR_W + IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic              src_taken,
  output logic              busy,
  output logic              tbl_rd_en,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [ENT_W-1:0]  tbl_rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [1:0]        wr_code
);
  localparam int TGT_LO  = 2;
  localparam int LAST_B  = IDX_W + 2;
  localparam int NEXT_LO = IDX_W + 3;

  logic walking_q;
  act_e ent_act;
  logic ent_last;
  logic [ADDR_W-1:0] ent_next;

  assign ent_act  = act_e'(tbl_rd_data[1:0]);
  assign wr_idx   = tbl_rd_data[TGT_LO +: IDX_W];
  assign ent_last = tbl_rd_data[LAST_B];
  assign ent_next = tbl_rd_data[NEXT_LO +: ADDR_W];

  assign busy    = walking_q;
  assign wr_en   = walking_q && !abort && ent_act != ACT_KEEP;
  assign wr_code = tbl_rd_data[1:0];

  always_comb begin
    tbl_rd_en = 1'b0;
    tbl_addr  = '0;
    if (abort) begin
      tbl_rd_en = 1'b0;
    end else if (walking_q) begin
      tbl_rd_en = !ent_last;
      tbl_addr  = ent_next;
    end else if (start) begin
      tbl_rd_en = 1'b1;
      tbl_addr  = ADDR_W'({src_idx, src_taken});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         walking_q <= 1'b0;
    else if (abort)     walking_q <= 1'b0;
    else if (walking_q) walking_q <= !ent_last;
    else if (start)     walking_q <= 1'b1;
  end

  // R7
  walk_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !walking_q && !abort) |=> busy);

  // R7
  walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tbl_rd_en) |=> !busy);
endmodule

// File: rtl/brc_alarm_latch.sv
module brc_alarm_latch #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail,
  input  logic [IDX_W-1:0] fail_idx,
  input  logic             clr,
  output logic             alarm,
  output logic [IDX_W-1:0] alarm_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm     <= 1'b0;
      alarm_idx <= '0;
    end else if (fail && (clr || !alarm)) begin
      alarm     <= 1'b1;
      alarm_idx <= fail_idx;
    end else if (clr) begin
      alarm <= 1'b0;
    end
  end

  // R2
  fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> alarm);

  // R9
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> (alarm && $stable(alarm_idx)));
endmodule

// File: rtl/brc_dir_checker.sv
module brc_dir_checker
  import brc_pkg::*;
#(
  parameter int NUM_BR    = 16,
  parameter int TBL_DEPTH = 64,
  localparam int IDX_W  = $clog2(NUM_BR),
  localparam int ADDR_W = $clog2(TBL_DEPTH),
  localparam int ENT_W  = ADDR_W + IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              func_start,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kind,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              req_taken,
  output logic              tbl_rd_en,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [ENT_W-1:0]  tbl_rd_data,
  input  logic              alarm_clr,
  output logic              alarm,
  output logic [IDX_W-1:0]  alarm_idx
);
  logic busy, accept, start_upd, verify_fail;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0] wr_code, rec_code, want_code;

  assign req_ready = !busy && !func_start;
  assign accept    = req_valid && req_ready;
  assign start_upd = accept && req_kind == REQ_UPDATE;
  assign want_code = req_taken ? ST_T : ST_NT;
  assign verify_fail = accept && req_kind == REQ_VERIFY &&
                       rec_code != ST_UN && rec_code != want_code;

  brc_state_bank #(.NUM_BR(NUM_BR), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clear_all(func_start),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code),
    .rd_idx(req_idx), .rd_code(rec_code)
  );

  brc_action_walker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .abort(func_start),
    .start(start_upd), .src_idx(req_idx), .src_taken(req_taken),
    .busy(busy), .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr),
    .tbl_rd_data(tbl_rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code)
  );

  brc_alarm_latch #(.IDX_W(IDX_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .fail(verify_fail), .fail_idx(req_idx),
    .clr(alarm_clr), .alarm(alarm), .alarm_idx(alarm_idx)
  );

  // R3
  unknown_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == REQ_VERIFY && rec_code == ST_UN && !alarm_clr)
      |=> alarm == $past(alarm));

  // R7
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_upd && !func_start) |=> !req_ready);
endmodule

// File: tb/brc_dir_checker_test.sv
module brc_dir_checker_test;
  localparam int NUM_BR = 16;
  localparam int DEPTH  = 64;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = 6;
  localparam int ENT_W  = ADDR_W + IDX_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic func_start = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_kind = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic req_taken = 1'b0;
  logic tbl_rd_en;
  logic [ADDR_W-1:0] tbl_addr;
  logic [ENT_W-1:0] tbl_rd_data;
  logic alarm_clr = 1'b0;
  logic alarm;
  logic [IDX_W-1:0] alarm_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [ENT_W-1:0] mem [DEPTH];

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (tbl_rd_en) tbl_rd_data <= mem[tbl_addr];
  end

  brc_dir_checker #(.NUM_BR(NUM_BR), .TBL_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .func_start(func_start),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_idx(req_idx), .req_taken(req_taken),
    .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr), .tbl_rd_data(tbl_rd_data),
    .alarm_clr(alarm_clr), .alarm(alarm), .alarm_idx(alarm_idx)
  );

  function automatic logic [ENT_W-1:0] ent(input logic [1:0] act, input int tgt,
                                           input bit last, input int nxt);
    return {ADDR_W'(nxt), last, IDX_W'(tgt), act};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic verify(input int idx, input bit tk, input bit clr = 1'b0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = 1'b0; req_idx = IDX_W'(idx); req_taken = tk;
    alarm_clr = clr;
    @(negedge clk);
    req_valid = 1'b0; alarm_clr = 1'b0;
  endtask

  task automatic update(input int idx, input bit tk, input int exp_len, input string req);
    int busy_cycles = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = 1'b1; req_idx = IDX_W'(idx); req_taken = tk;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy_cycles < 40) begin
      busy_cycles++;
      @(negedge clk);
    end
    if (exp_len >= 0) check(req, busy_cycles, exp_len);
  endtask

  task automatic clear_alarm();
    @(negedge clk);
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 alarm after reset", alarm, 0);
    check("R7 ready after reset", req_ready, 1);
    verify(3, 1'b1);
    verify(3, 1'b0);
    check("R3 unknown accepts both", alarm, 0);
  endtask

  task automatic t_chain();
    // branch 1 taken: self set taken, then branch 5 set taken
    mem[3]  = ent(2'b01, 1, 1'b0, 40);
    mem[40] = ent(2'b01, 5, 1'b1, 0);
    update(1, 1'b1, 2, "R7 two-entry list busy cycles");
    verify(5, 1'b1);
    verify(1, 1'b1);
    check("R6 self and R4 target taken pass", alarm, 0);
    verify(5, 1'b0);
    check("R2 mismatch alarm", alarm, 1);
    check("R2 alarm index", alarm_idx, 5);
    verify(1, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 alarm sticky", alarm, 1);
    check("R9 first index kept", alarm_idx, 5);
    clear_alarm();
    check("R9 alarm cleared", alarm, 0);
  endtask

  task automatic t_outcomes();
    mem[4] = ent(2'b10, 2, 1'b1, 0);
    mem[5] = ent(2'b11, 2, 1'b1, 0);
    update(2, 1'b0, 1, "R7 one-entry list busy cycles");
    verify(2, 1'b1);
    check("R5 not-taken list sets not-taken", alarm, 1);
    check("R8 verify sees prior update", alarm_idx, 2);
    clear_alarm();
    verify(2, 1'b1);
    check("R11 verify left record unchanged", alarm, 1);
    clear_alarm();
    update(2, 1'b1, 1, "R5 taken list busy cycles");
    verify(2, 1'b1);
    verify(2, 1'b0);
    check("R5 taken list sets unknown", alarm, 0);
  endtask

  task automatic t_keep();
    mem[15] = ent(2'b00, 5, 1'b0, 41);
    mem[41] = ent(2'b10, 7, 1'b1, 0);
    update(7, 1'b1, 2, "R4 keep list busy cycles");
    verify(5, 1'b0);
    check("R10 keep left branch 5 taken", alarm, 1);
    check("R10 index", alarm_idx, 5);
    clear_alarm();
    verify(7, 1'b1);
    check("R4 second entry applied", alarm_idx, 7);
    check("R4 second entry alarm", alarm, 1);
    clear_alarm();
  endtask

  task automatic t_func_start();
    @(negedge clk);
    func_start = 1'b1;
    #1;
    check("R8 ready low during func_start", req_ready, 0);
    @(negedge clk);
    func_start = 1'b0;
    verify(5, 1'b0);
    verify(7, 1'b1);
    check("R1 records unknown after func_start", alarm, 0);
  endtask

  task automatic t_clr_collide();
    update(1, 1'b1, 2, "R7 repeated list");
    verify(5, 1'b0);
    check("R9 setup alarm idx", alarm_idx, 5);
    verify(1, 1'b0, 1'b1);
    check("R9 clear with new failure keeps alarm", alarm, 1);
    check("R9 clear with new failure index", alarm_idx, 1);
    clear_alarm();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ent(2'b00, 0, 1'b1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain();
    t_outcomes();
    t_keep();
    t_func_start();
    t_clr_collide();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule